// File: doc/BRIEF.md
# Upper Memory Shadow Attribute Controller

This block decides, for every memory address a processor issues, where the access belongs in the upper memory area between 0xA0000 and 0xFFFFF. Reads can be served by internal shadow RAM or by the external bus. Writes can go to internal RAM, or they can be dropped so that the shadowed copy stays read-only. Software sets up the decision through seven 16-bit configuration registers on a small I/O port interface. The block keeps a registered attribute map built from those writes. A purely combinational lookup turns the current memory address into three attribute outputs.

The map has two granularities. In coarse mode, one configuration word sets three 128 KB regions. The video window 0xA0000–0xBFFFF also has its own write-protect control. In extended mode, a second word sets eight 32 KB segments that cover 0xC0000–0xFFFFF. A register bit chooses the mode. A write that carries the lock bit freezes the map until the next reset.

The lock is a two-state machine:
- OPEN is the state after reset. While in OPEN, mode-appropriate writes update the map.
- The single transition, OPEN to LOCKED, fires on a write to the memory-configuration register with bit 15 set.
- LOCKED has no exit except reset.

Top module: `shadow_map_ctrl`

## Requirements
- R1: Registers are at even I/O addresses 0x22, 0x24, 0x26, 0x28, 0x2A, 0x2C and 0x2E. Each stores a full 16-bit write and reads back the last value written, including while the map is locked. After reset every register reads 0x0000, except 0x28, which reads 0x00F9.
- R2: An I/O read at any address other than those seven returns 0xFFFF.
- R3: Attribute encoding on the outputs is {rd_internal, wr_internal, wr_block}:
  - external is 000
  - read-only shadow is 101
  - read/write shadow is 110
  
  After reset every address maps to external.
- R4: In coarse mode, a write to 0x22 with bit 10 set makes 0xA0000–0xBFFFF shadowed. Bit 11 then selects read/write (1) or read-only (0). With bit 10 clear, the region is external.
- R5: In coarse mode, a write to 0x22 sets 0xC0000–0xDFFFF to read/write when bit 9 is set and external otherwise. Bit 0 does the same for 0xE0000–0xFFFFF.
- R6: In extended mode, a write to 0x2E sets segment i (i = 0..7, covering 0xC0000 + i·0x8000 to 0xC0000 + i·0x8000 + 0x7FFF) as follows:
  - bit i+8 clear gives external
  - bit i+8 set and bit i set gives read-only
  - bit i+8 set and bit i clear gives read/write
- R7: Bit 0 of 0x2C selects extended mode (1) or coarse mode (0). The mode in force when a write arrives is the one that applies. A write to 0x2E leaves the map unchanged in coarse mode, and a write to 0x22 leaves the map unchanged in extended mode.
- R8: A write to 0x22 with bit 15 set moves OPEN to LOCKED and does not itself change the map. In LOCKED, no write changes the map, even after bit 15 has been written back to 0. Only reset returns to OPEN.
- R9: Every address below 0xA0000, and every address above 0xFFFFF, reports external (000).
- R10: In extended mode, 0xA0000–0xBFFFF keeps the attribute last set in coarse mode.
- R11: A map change appears on the outputs after the clock edge that samples the I/O write, and not before it.
- R12: The outputs never show wr_internal and wr_block together. Neither of them is ever set without rd_internal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, sampled on the rising edge |
| io_addr | input | IO_AW (8) | I/O register address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | Combinational read data for io_addr |
| mem_addr | input | ADDR_W (20) | Memory access address to classify |
| rd_internal | output | 1 | Read is served by internal shadow RAM |
| wr_internal | output | 1 | Write goes to internal shadow RAM |
| wr_block | output | 1 | Write is dropped (read-only shadow) |

## Verification
A wrong lock state, mode bit or map entry has no internal window. It shows at the attribute outputs on the first address probed in the affected region, one clock after the write that should or should not have changed it. The bench therefore re-sweeps every region boundary and a spread of interior addresses after each configuration write, and compares the results against a model built only from the requirements. A lock that fails to stick, or a write accepted in the wrong mode, changes the attributes of some swept address in that same sweep. Register storage faults show up at once on the read-back port.

// File: rtl/shadow_map_pkg.sv
package shadow_map_pkg;

    // Attribute code: bit 0 = internal read, bit 1 = internal write
    typedef enum logic [1:0] {
        ATTR_EXT = 2'b00,
        ATTR_RO  = 2'b01,
        ATTR_RW  = 2'b11
    } attr_t;

    localparam int          NUM_REGS   = 7;
    localparam int          IDX_W      = $clog2(NUM_REGS);
    localparam logic [7:0]  REG_BASE   = 8'h22;
    localparam int          IDX_MEMCFG = 0;   // 0x22
    localparam int          IDX_RANGE  = 3;   // 0x28
    localparam int          IDX_GRAN   = 5;   // 0x2C
    localparam int          IDX_SEGCFG = 6;   // 0x2E
    localparam logic [15:0] RANGE_RST  = 16'h00F9;

    // Field positions of the memory-configuration word
    localparam int BIT_HIGH_EN  = 0;
    localparam int BIT_MID_EN   = 9;
    localparam int BIT_LOW_EN   = 10;
    localparam int BIT_LOW_WR   = 11;
    localparam int BIT_LOCK     = 15;

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
    import shadow_map_pkg::*;
#(
    parameter int IO_AW  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              ext_mode,
    output logic              upd_coarse,
    output logic              upd_ext,
    output logic              locked
);

    localparam logic [IO_AW-1:0] BASE_A = IO_AW'(REG_BASE);
    localparam logic [IO_AW-1:0] SPAN_A = IO_AW'(2 * (NUM_REGS - 1));

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_LOCKED = 1'b1
    } lk_state_t;

    lk_state_t              state_q, state_d;
    logic [DATA_W-1:0]      regs_q [NUM_REGS];
    logic [IO_AW-1:0]       ofs;
    logic                   hit;
    logic [IDX_W-1:0]       idx;
    logic                   wr_memcfg, wr_segcfg;

    // Address decode: even offsets from the base
    assign ofs       = io_addr - BASE_A;
    assign hit       = !ofs[0] && (ofs <= SPAN_A);
    assign idx       = IDX_W'(ofs >> 1);
    assign wr_memcfg = io_wr && hit && (idx == IDX_W'(IDX_MEMCFG));
    assign wr_segcfg = io_wr && hit && (idx == IDX_W'(IDX_SEGCFG));

    // Register storage, writes accepted in every lock state
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_V =
            (g == IDX_RANGE) ? DATA_W'(RANGE_RST) : '0;
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= RST_V;
            else if (io_wr && hit && (idx == IDX_W'(g)))
                regs_q[g] <= io_wdata;
        end
    end

    assign io_rdata = hit ? regs_q[idx] : '1;
    assign ext_mode = regs_q[IDX_GRAN][0];

    // Lock state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LK_OPEN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (wr_memcfg && io_wdata[BIT_LOCK]) state_d = LK_LOCKED;
            LK_LOCKED: state_d = LK_LOCKED;
        endcase
    end

    // Outputs per state
    always_comb begin
        upd_coarse = 1'b0;
        upd_ext    = 1'b0;
        locked     = 1'b0;
        unique case (state_q)
            LK_OPEN: begin
                upd_coarse = wr_memcfg && !ext_mode && !io_wdata[BIT_LOCK];
                upd_ext    = wr_segcfg && ext_mode;
            end
            LK_LOCKED: locked = 1'b1;
        endcase
    end

    // R8: the lock holds until reset
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_LOCKED) |=> (state_q == LK_LOCKED));

    // R8: entering the lock never carries a map update with it
    p_lock_entry_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_OPEN && state_d == LK_LOCKED) |-> !upd_coarse);

endmodule

// File: rtl/shadow_attr_map.sv
module shadow_attr_map
    import shadow_map_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SEG_COUNT = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd_coarse,
    input  logic                      upd_ext,
    input  logic [DATA_W-1:0]         cfg_word,
    output logic [1:0]                low_attr,
    output logic [SEG_COUNT-1:0][1:0] seg_attr
);

    localparam int HALF   = SEG_COUNT / 2;
    localparam int EN_OFS = DATA_W / 2;

    attr_t low_next, mid_next, high_next;

    always_comb begin
        if (!cfg_word[BIT_LOW_EN])     low_next = ATTR_EXT;
        else if (cfg_word[BIT_LOW_WR]) low_next = ATTR_RW;
        else                           low_next = ATTR_RO;
        mid_next  = cfg_word[BIT_MID_EN]  ? ATTR_RW : ATTR_EXT;
        high_next = cfg_word[BIT_HIGH_EN] ? ATTR_RW : ATTR_EXT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            low_attr <= ATTR_EXT;
        else if (upd_coarse)
            low_attr <= low_next;
    end

    for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
        attr_t coarse_v, ext_v;
        assign coarse_v = (s < HALF) ? mid_next : high_next;
        assign ext_v    = !cfg_word[s + EN_OFS] ? ATTR_EXT :
                          (cfg_word[s] ? ATTR_RO : ATTR_RW);
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_attr[s] <= ATTR_EXT;
            else if (upd_coarse)
                seg_attr[s] <= coarse_v;
            else if (upd_ext)
                seg_attr[s] <= ext_v;
        end
    end

    // R11: the map moves only on a sampled update
    p_map_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_coarse || upd_ext) |=> ($stable(low_attr) && $stable(seg_attr)));

endmodule

// File: rtl/shadow_attr_lookup.sv
module shadow_attr_lookup
    import shadow_map_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int SEG_COUNT = 8,
    parameter int SEG_SHIFT = 15
) (
    input  logic [ADDR_W-1:0]         mem_addr,
    input  logic [1:0]                low_attr,
    input  logic [SEG_COUNT-1:0][1:0] seg_attr,
    output logic                      rd_internal,
    output logic                      wr_internal,
    output logic                      wr_block
);

    localparam int                SEG_W     = $clog2(SEG_COUNT);
    localparam logic [ADDR_W-1:0] LOW_BASE  = ADDR_W'(20'hA0000);
    localparam logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(20'hC0000);
    localparam logic [ADDR_W-1:0] AREA_TOP  =
        HIGH_BASE + ADDR_W'(SEG_COUNT << SEG_SHIFT) - 1'b1;

    logic              in_low, in_high;
    logic [ADDR_W-1:0] seg_ofs;
    logic [SEG_W-1:0]  seg_idx;
    logic [1:0]        attr;

    assign in_low  = (mem_addr >= LOW_BASE) && (mem_addr < HIGH_BASE);
    assign in_high = (mem_addr >= HIGH_BASE) && (mem_addr <= AREA_TOP);
    assign seg_ofs = mem_addr - HIGH_BASE;
    assign seg_idx = SEG_W'(seg_ofs >> SEG_SHIFT);

    always_comb begin
        if (in_low)       attr = low_attr;
        else if (in_high) attr = seg_attr[seg_idx];
        else              attr = ATTR_EXT;
    end

    assign rd_internal = attr[0];
    assign wr_internal = attr[1];
    assign wr_block    = attr[0] && !attr[1];

endmodule

// File: rtl/shadow_map_ctrl.sv
module shadow_map_ctrl
    import shadow_map_pkg::*;
#(
    parameter int IO_AW     = 8,
    parameter int ADDR_W    = 20,
    parameter int SEG_COUNT = 8,
    parameter int SEG_SHIFT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [15:0]       io_wdata,
    output logic [15:0]       io_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              rd_internal,
    output logic              wr_internal,
    output logic              wr_block
);

    localparam int DATA_W = 16;

    logic                      ext_mode, upd_coarse, upd_ext, lock_q;
    logic [1:0]                low_attr;
    logic [SEG_COUNT-1:0][1:0] seg_attr;

    shadow_cfg_regs #(.IO_AW(IO_AW), .DATA_W(DATA_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_wr      (io_wr),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .ext_mode   (ext_mode),
        .upd_coarse (upd_coarse),
        .upd_ext    (upd_ext),
        .locked     (lock_q)
    );

    shadow_attr_map #(.DATA_W(DATA_W), .SEG_COUNT(SEG_COUNT)) i_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_coarse (upd_coarse),
        .upd_ext    (upd_ext),
        .cfg_word   (io_wdata),
        .low_attr   (low_attr),
        .seg_attr   (seg_attr)
    );

    shadow_attr_lookup #(.ADDR_W(ADDR_W), .SEG_COUNT(SEG_COUNT),
                         .SEG_SHIFT(SEG_SHIFT)) i_lookup (
        .mem_addr    (mem_addr),
        .low_attr    (low_attr),
        .seg_attr    (seg_attr),
        .rd_internal (rd_internal),
        .wr_internal (wr_internal),
        .wr_block    (wr_block)
    );

    // R8: a locked configuration freezes the whole map
    p_lock_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(low_attr) && $stable(seg_attr)));

    // R10: extended mode never touches the video window
    p_ext_keeps_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> $stable(low_attr));

    // R7: in coarse mode the segment word has no path into the map
    p_coarse_ignores_seg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && !(io_wr && io_addr == IO_AW'(REG_BASE))) |=> $stable(seg_attr));

    // R12: attribute combination is always legal
    p_attr_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_internal && wr_block) && (!(wr_internal || wr_block) || rd_internal));

    // R9: below the upper memory area everything is external
    p_outside_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr < ADDR_W'(20'hA0000)) |-> !(rd_internal || wr_internal || wr_block));

endmodule

// File: tb/test_shadow_map_ctrl.sv
module test_shadow_map_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_wr;
    logic [7:0]  io_addr;
    logic [15:0] io_wdata;
    logic [15:0] io_rdata;
    logic [19:0] mem_addr;
    logic        rd_internal, wr_internal, wr_block;

    always #10 clk = ~clk;

    shadow_map_ctrl i_shadow_map_ctrl (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
        .rd_internal(rd_internal), .wr_internal(wr_internal), .wr_block(wr_block)
    );

    int n_run = 0;
    int n_fail = 0;

    // Requirement-level model: 0 = external, 1 = read-only, 2 = read/write
    int          m_low;
    int          m_seg [8];
    bit          m_lock, m_ext;
    logic [15:0] m_reg [7];

    task automatic model_reset();
        m_low = 0; m_lock = 0; m_ext = 0;
        for (int i = 0; i < 8; i++) m_seg[i] = 0;
        for (int i = 0; i < 7; i++) m_reg[i] = (i == 3) ? 16'h00F9 : 16'h0000;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [15:0] d);
        if (!m_lock) begin
            if (a == 8'h22 && d[15]) m_lock = 1;
            else if (a == 8'h22 && !m_ext) begin
                m_low = !d[10] ? 0 : (d[11] ? 2 : 1);
                for (int i = 0; i < 4; i++) m_seg[i] = d[9] ? 2 : 0;
                for (int i = 4; i < 8; i++) m_seg[i] = d[0] ? 2 : 0;
            end else if (a == 8'h2E && m_ext) begin
                for (int i = 0; i < 8; i++) m_seg[i] = !d[i+8] ? 0 : (d[i] ? 1 : 2);
            end
        end
        if (a >= 8'h22 && a <= 8'h2E && !a[0]) m_reg[(a - 8'h22) >> 1] = d;
        if (a == 8'h2C) m_ext = d[0];
    endtask

    function automatic logic [2:0] exp_attr(input logic [19:0] a);
        int c;
        c = 0;
        if (a >= 20'hA0000 && a < 20'hC0000) c = m_low;
        else if (a >= 20'hC0000) c = m_seg[(a - 20'hC0000) >> 15];
        case (c)
            1: return 3'b101;
            2: return 3'b110;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [19:0] a);
        mem_addr = a;
        #1;
        chk(req, {12'h0, a, 1'b0, rd_internal, wr_internal, wr_block} , {12'h0, a, 1'b0, exp_attr(a)});
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < 64; k++)
            probe(req, 20'((k << 14) | ((k * 613) & 16'h3FFF)));
        for (int j = 0; j < 8; j++) begin
            probe(req, 20'(20'hC0000 + j * 20'h8000));
            probe(req, 20'(20'hC0000 + j * 20'h8000 - 1));
        end
        probe(req, 20'h9FFFF);
        probe(req, 20'hA0000);
        probe(req, 20'hFFFFF);
    endtask

    task automatic io_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] e);
        @(negedge clk);
        io_addr = a;
        #1;
        chk(req, {8'h0, a, io_rdata}, {8'h0, a, e});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; io_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        io_addr = 8'h00; io_wdata = 16'h0; mem_addr = 20'h0;
        do_reset();

        // R1 reset values, R2 unmapped reads, R3/R9 all external
        for (int i = 0; i < 7; i++) rd_chk("R1 reset", 8'(8'h22 + 2 * i), m_reg[i]);
        rd_chk("R2 unmapped", 8'h20, 16'hFFFF);
        rd_chk("R2 unmapped", 8'h23, 16'hFFFF);
        rd_chk("R2 unmapped", 8'h2F, 16'hFFFF);
        rd_chk("R2 unmapped", 8'h30, 16'hFFFF);
        rd_chk("R2 unmapped", 8'hFF, 16'hFFFF);
        sweep("R3 R9 reset map");

        // R1 storage of the comparison registers
        io_write(8'h24, 16'hA55A); io_write(8'h26, 16'h1234);
        io_write(8'h28, 16'hFFFF); io_write(8'h2A, 16'h8001);
        for (int i = 1; i < 5; i++) rd_chk("R1 readback", 8'(8'h22 + 2 * i), m_reg[i]);

        // R4 R5 coarse mode, all combinations of the four control bits
        for (int v = 0; v < 16; v++) begin
            io_write(8'h22, {4'h0, v[3], v[2], v[1], 8'h0, v[0]});
            rd_chk("R1 memcfg readback", 8'h22, m_reg[0]);
            sweep("R4 R5 coarse");
        end

        // R7 segment word ignored in coarse mode
        io_write(8'h22, 16'h0401);
        io_write(8'h2E, 16'hFF0F);
        rd_chk("R1 segcfg readback", 8'h2E, 16'hFF0F);
        sweep("R7 coarse ignores 0x2E");

        // R6 extended mode sweep over all enable masks
        io_write(8'h2C, 16'h0001);
        rd_chk("R1 gran readback", 8'h2C, 16'h0001);
        for (int e = 0; e < 256; e++) begin
            logic [7:0] ro;
            ro = 8'({e[3:0], e[7:4]} ^ 8'h3C);
            io_write(8'h2E, {8'(e), ro});
            sweep("R6 R10 extended");
        end

        // R7 R10 memcfg ignored in extended mode
        io_write(8'h22, 16'h0E01);
        sweep("R7 R10 ext ignores 0x22");

        // R11 timing: old value before the edge, new after
        io_write(8'h2C, 16'h0000);
        io_write(8'h22, 16'h0000);
        @(negedge clk);
        io_wr = 1'b1; io_addr = 8'h22; io_wdata = 16'h0001;
        probe("R11 before edge", 20'hF0000);
        @(negedge clk);
        io_wr = 1'b0;
        model_write(8'h22, 16'h0001);
        probe("R11 after edge", 20'hF0000);

        // R8 lock
        io_write(8'h22, 16'h0C01);
        sweep("R4 pre-lock");
        io_write(8'h22, 16'h8602);
        rd_chk("R8 lock readback", 8'h22, 16'h8602);
        sweep("R8 lock write quiet");
        io_write(8'h22, 16'h0000);
        rd_chk("R8 cleared bit readback", 8'h22, 16'h0000);
        sweep("R8 lock persists");
        io_write(8'h2C, 16'h0001);
        io_write(8'h2E, 16'hFF00);
        sweep("R8 ext locked");

        // Reset clears the lock
        do_reset();
        rd_chk("R1 reset again", 8'h22, 16'h0000);
        rd_chk("R1 reset range", 8'h28, 16'h00F9);
        sweep("R3 reset map again");
        io_write(8'h22, 16'h0200);
        sweep("R5 R8 unlocked after reset");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule